// File: doc/BRIEF.md
# Burst Line Transfer Controller

This block sits on the processor side of a 64-bit system bus. It moves whole 32-byte cache lines in both directions: line fills, which read a line in from memory, and writebacks, which write a modified line out. The cache side hands it one request at a time. Each request carries a line address, an operation and, for fills, a cacheable flag. The block then runs the bus cycle. It drives a one-clock address strobe together with the address, the direction and a cache-intent flag. It counts ready strobes from system logic, and it returns each fill quadword with its position in the line.

For fills, the decision between a four-beat burst and a single transfer is made late. Cache-enable is sampled together with the first ready, and it must agree with the cache intent. Beats arrive in interleaved order: the index of each quadword is the starting index XOR the beat number. Writebacks are always bursts. They present the quadword that each beat expects, starting one clock after the strobe and advancing on every ready.

System logic can ask for the next address early by asserting next-address with the first ready of a burst. A waiting request then gets its strobe while the current burst is still moving data. Only one such early cycle may be outstanding.

Top module: `burst_line_ctrl`

## Requirements
- R1: After reset, the strobe, data-drive enable, fill-valid and done outputs are low, and req_ready_o is high.
- R2: Each accepted request produces exactly one strobe cycle. That cycle shows the line address with bits 2:0 cleared, bus_wr_o = 1 for a writeback and 0 for a fill, and bus_cache_o = 1 for any writeback or for a fill with req_cache_i = 1.
- R3: Ready is sampled only from the cycle after the strobe cycle. A ready seen during a strobe cycle with no transfer in progress has no effect.
- R4: A fill whose cache intent is set and whose cache-enable is high with the first ready takes exactly four readies. It then pulses done_o with done_burst_o = 1 one cycle after the fourth ready.
- R5: The quadword index of beat k (k = 0..3) is addr[4:3] XOR k. It is reported on rd_qw_o together with that beat's data, one cycle after the ready that carried it.
- R6: A fill with cache-enable low at its first ready, or with no cache intent, ends after that single ready with done_burst_o = 0. Cache-enable on later beats of a burst is not consulted.
- R7: Cycles without ready advance nothing. The bus-side outputs hold their values, and the done pulse comes (waits+1)*beats+1 cycles after the strobe cycle.
- R8: A writeback is always a four-beat burst, whatever cache-enable shows. From the cycle after the strobe, it drives bus_dat_oe_o and presents on bus_dat_o the line quadword req_line_i[64*q +: 64], where q = addr[4:3] XOR beat. The data advances after each ready.
- R9: When no early cycle is pending, at least one idle clock separates the end of a cycle from the next strobe, and the strobe never coincides with done_o.
- R10: If next-address is high with the first ready of a burst, a waiting request is accepted and strobed before that burst ends. Its data phase starts only after the burst completes.
- R11: Next-address is ignored on later beats and on single transfers. While one early cycle is pending, no further request is accepted until the current burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_op_i | input | 1 | 0 = line fill, 1 = writeback |
| req_cache_i | input | 1 | Fill is cacheable (may burst) |
| req_addr_i | input | ADDR_W | Byte address; bits 4:3 give the starting quadword |
| req_line_i | input | BEATS*DATA_W | Writeback line, quadword q at bits 64*q |
| bus_ads_o | output | 1 | Address strobe, one clock per cycle |
| bus_addr_o | output | ADDR_W | Cycle address, low three bits zero |
| bus_wr_o | output | 1 | Cycle is a write |
| bus_cache_o | output | 1 | Cache intent for the cycle |
| bus_dat_o | output | DATA_W | Write data |
| bus_dat_oe_o | output | 1 | Write data is being driven |
| bus_dat_i | input | DATA_W | Read data |
| bus_rdy_i | input | 1 | Ready from system logic |
| bus_ken_i | input | 1 | Cache-enable from system logic |
| bus_na_i | input | 1 | Next-address request from system logic |
| rd_valid_o | output | 1 | Fill quadword valid |
| rd_qw_o | output | $clog2(BEATS) | Fill quadword index within the line |
| rd_data_o | output | DATA_W | Fill quadword data |
| done_o | output | 1 | Cycle finished (pulse) |
| done_burst_o | output | 1 | Finished cycle was a burst |

## Verification
Fills are started at each of the four quadword positions. Zero and multi-clock wait states tell interleaved ordering and beat counting apart from simple sequential stepping. Cacheable fills with cache-enable high and then low, and a fill without cache intent, separate the late burst decision from a decision taken at the strobe. Cache-enable is inverted on later beats to show that it is not read again. A ready pulse during the strobe cycle shows that early readies are not counted. Runs with next-address on the first beat, on the second beat, and with three queued requests distinguish a legal early strobe from an ignored request and from a second early cycle.

// File: rtl/blt_pkg.sv
package blt_pkg;
  typedef enum logic {
    OP_FILL = 1'b0,
    OP_WB   = 1'b1
  } blt_op_e;
endpackage

// File: rtl/blt_order.sv
module blt_order #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [IDX_W-1:0] beat_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  // interleaved line order
  assign idx_o  = start_i ^ beat_i;
  assign last_o = &beat_i;
endmodule

// File: rtl/blt_qw_sel.sv
module blt_qw_sel #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4
) (
  input  logic [BEATS*DATA_W-1:0]   line_i,
  input  logic [$clog2(BEATS)-1:0]  idx_i,
  output logic [DATA_W-1:0]         q_o
);
  logic [DATA_W-1:0] words [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    assign words[g] = line_i[g*DATA_W +: DATA_W];
  end

  assign q_o = words[idx_i];
endmodule

// File: rtl/burst_line_ctrl.sv
module burst_line_ctrl
  import blt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_op_i,
  input  logic                           req_cache_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [BEATS*DATA_W-1:0]        req_line_i,
  output logic                           bus_ads_o,
  output logic [ADDR_W-1:0]              bus_addr_o,
  output logic                           bus_wr_o,
  output logic                           bus_cache_o,
  output logic [DATA_W-1:0]              bus_dat_o,
  output logic                           bus_dat_oe_o,
  input  logic [DATA_W-1:0]              bus_dat_i,
  input  logic                           bus_rdy_i,
  input  logic                           bus_ken_i,
  input  logic                           bus_na_i,
  output logic                           rd_valid_o,
  output logic [$clog2(BEATS)-1:0]       rd_qw_o,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic                           done_o,
  output logic                           done_burst_o
);
  localparam int IDX_W  = $clog2(BEATS);
  localparam int OFS_W  = $clog2(DATA_W/8);
  localparam int LINE_W = BEATS*DATA_W;

  // address phase
  logic              ads_q, wr_q, cache_q;
  logic [ADDR_W-1:0] addr_q;
  // strobed cycle waiting for its data phase
  logic              nxt_v, nxt_wr, nxt_int;
  logic [IDX_W-1:0]  nxt_qw;
  logic [LINE_W-1:0] nxt_line;
  // cycle in data phase
  logic              act_q, cur_wr, cur_int, cur_seen, cur_burst, cur_na;
  logic [IDX_W-1:0]  cur_qw, cur_beat;
  logic [LINE_W-1:0] cur_line;
  // results
  logic              rd_valid_q, done_q, done_burst_q;
  logic [IDX_W-1:0]  rd_qw_q;
  logic [DATA_W-1:0] rd_data_q;

  logic             req_wr, req_int, rdy_now, burst_now, at_last, cur_end;
  logic             idle_take, pipe_take, take, promote, na_set;
  logic [IDX_W-1:0] idx;

  assign req_wr  = (req_op_i == OP_WB);
  assign req_int = req_wr | req_cache_i;

  assign rdy_now   = act_q & bus_rdy_i;
  // late decision: intent and cache-enable agree on the first ready
  assign burst_now = cur_seen ? cur_burst : (cur_int & (cur_wr | bus_ken_i));

  blt_order #(.IDX_W(IDX_W)) u_order (
    .start_i (cur_qw),
    .beat_i  (cur_beat),
    .idx_o   (idx),
    .last_o  (at_last)
  );

  blt_qw_sel #(.DATA_W(DATA_W), .BEATS(BEATS)) u_sel (
    .line_i (cur_line),
    .idx_i  (idx),
    .q_o    (bus_dat_o)
  );

  assign cur_end   = rdy_now & (~burst_now | at_last);
  assign na_set    = rdy_now & ~cur_seen & burst_now & bus_na_i;
  assign idle_take = ~act_q & ~ads_q & ~nxt_v;
  assign pipe_take = act_q & cur_na & ~nxt_v & ~ads_q & ~cur_end;
  assign req_ready_o = idle_take | pipe_take;
  assign take      = req_valid_i & req_ready_o;
  assign promote   = nxt_v & (~act_q | cur_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ads_q   <= 1'b0;
      wr_q    <= 1'b0;
      cache_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      ads_q <= take;
      if (take) begin
        addr_q  <= {req_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        wr_q    <= req_wr;
        cache_q <= req_int;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_v    <= 1'b0;
      nxt_wr   <= 1'b0;
      nxt_int  <= 1'b0;
      nxt_qw   <= '0;
      nxt_line <= '0;
    end else if (take) begin
      nxt_v    <= 1'b1;
      nxt_wr   <= req_wr;
      nxt_int  <= req_int;
      nxt_qw   <= req_addr_i[OFS_W +: IDX_W];
      nxt_line <= req_line_i;
    end else if (promote) begin
      nxt_v <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      cur_wr    <= 1'b0;
      cur_int   <= 1'b0;
      cur_seen  <= 1'b0;
      cur_burst <= 1'b0;
      cur_na    <= 1'b0;
      cur_qw    <= '0;
      cur_beat  <= '0;
      cur_line  <= '0;
    end else if (promote) begin
      act_q     <= 1'b1;
      cur_wr    <= nxt_wr;
      cur_int   <= nxt_int;
      cur_qw    <= nxt_qw;
      cur_line  <= nxt_line;
      cur_beat  <= '0;
      cur_seen  <= 1'b0;
      cur_burst <= 1'b0;
      cur_na    <= 1'b0;
    end else if (cur_end) begin
      act_q  <= 1'b0;
      cur_na <= 1'b0;
    end else if (rdy_now) begin
      cur_beat  <= cur_beat + 1'b1;
      cur_seen  <= 1'b1;
      cur_burst <= burst_now;
      if (na_set) cur_na <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q   <= 1'b0;
      rd_qw_q      <= '0;
      rd_data_q    <= '0;
      done_q       <= 1'b0;
      done_burst_q <= 1'b0;
    end else begin
      rd_valid_q   <= rdy_now & ~cur_wr;
      done_q       <= cur_end;
      done_burst_q <= cur_end & burst_now;
      if (rdy_now & ~cur_wr) begin
        rd_qw_q   <= idx;
        rd_data_q <= bus_dat_i;
      end
    end
  end

  assign bus_ads_o    = ads_q;
  assign bus_addr_o   = addr_q;
  assign bus_wr_o     = wr_q;
  assign bus_cache_o  = cache_q;
  assign bus_dat_oe_o = act_q & cur_wr;
  assign rd_valid_o   = rd_valid_q;
  assign rd_qw_o      = rd_qw_q;
  assign rd_data_o    = rd_data_q;
  assign done_o       = done_q;
  assign done_burst_o = done_burst_q;

  AST_ADS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_q |=> !ads_q); // R2
  AST_NO_EARLY_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_q && !act_q) |=> (cur_beat == '0 && !cur_seen)); // R3
  AST_BURST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_burst_o |-> ($past(cur_beat) == IDX_W'(BEATS-1))); // R4
  AST_HOLD_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !bus_rdy_i) |=> $stable(bus_dat_o)); // R7
  AST_WB_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_q && wr_q && !act_q) |=> bus_dat_oe_o); // R8
  AST_IDLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_end && !nxt_v) |=> !ads_q); // R9
  AST_EARLY_NEEDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_q && act_q) |-> (cur_seen && cur_burst)); // R10
endmodule

// File: tb/sim_burst_line_ctrl.sv
module sim_burst_line_ctrl;
  import blt_pkg::*;
  localparam int AW = 32, DW = 64, NB = 4, IW = 2, LW = NB*DW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid_i = 0, req_op_i = 0, req_cache_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [LW-1:0] req_line_i = '0;
  logic          req_ready_o;
  logic          bus_ads_o, bus_wr_o, bus_cache_o, bus_dat_oe_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_dat_o, bus_dat_i = '0;
  logic          bus_rdy_i = 0, bus_ken_i = 0, bus_na_i = 0;
  logic          rd_valid_o, done_o, done_burst_o;
  logic [IW-1:0] rd_qw_o;
  logic [DW-1:0] rd_data_o;

  burst_line_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_ready_o, .req_op_i, .req_cache_i, .req_addr_i, .req_line_i,
    .bus_ads_o, .bus_addr_o, .bus_wr_o, .bus_cache_o, .bus_dat_o, .bus_dat_oe_o,
    .bus_dat_i, .bus_rdy_i, .bus_ken_i, .bus_na_i,
    .rd_valid_o, .rd_qw_o, .rd_data_o, .done_o, .done_burst_o
  );

  int errs = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [IW-1:0] qw; logic [DW-1:0] d; } rd_t;
  typedef struct { logic [AW-1:0] a; logic wr; logic c; } ads_t;
  rd_t  rdq[$];
  bit   dq[$];
  ads_t aq[$];
  int   ads_cyc[$], done_cyc[$];

  int waits = 0, na_beat = -1;
  bit ken_cfg = 1, junk = 0;

  bit   have_cur = 0;
  ads_t pend[$];

  function automatic logic [DW-1:0] memq(logic [AW-1:0] a, int q);
    return {~a, 16'h5EED, 16'(q)};
  endfunction
  function automatic logic [DW-1:0] wbq(logic [AW-1:0] a, int q);
    return {a, 16'hC0DE, 16'(q)};
  endfunction
  function automatic logic [LW-1:0] wbline(logic [AW-1:0] a);
    logic [LW-1:0] l;
    for (int k = 0; k < NB; k++) l[k*DW +: DW] = wbq(a, k);
    return l;
  endfunction

  task automatic ck(string r, string w, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, w, act, exp);
    end
  endtask

  // bus responder: system-logic model
  initial begin
    ads_t cur;
    int beat, nbeats, wl;
    logic [IW-1:0] q;
    beat = 0; nbeats = 0; wl = 0;
    forever begin
      @(negedge clk);
      bus_rdy_i = 0; bus_ken_i = 0; bus_na_i = 0; bus_dat_i = '0;
      if (!rst_n) continue;
      if (!have_cur && pend.size() > 0) begin
        cur = pend.pop_front();
        have_cur = 1; beat = 0; wl = waits;
        nbeats = (cur.wr || (cur.c && ken_cfg)) ? NB : 1;
      end
      if (have_cur) begin
        if (wl > 0) wl--;
        else begin
          q = cur.a[4:3] ^ 2'(beat);
          bus_rdy_i = 1;
          bus_ken_i = (beat == 0) ? ken_cfg : !ken_cfg;
          bus_na_i  = (beat == na_beat);
          if (!cur.wr) bus_dat_i = memq(cur.a, int'(q));
          else begin
            ck("R8", "writeback quadword", bus_dat_o, wbq(cur.a, int'(q)));
            ck("R8", "data drive enable", 64'(bus_dat_oe_o), 64'd1);
          end
          beat++; wl = waits;
          if (beat == nbeats) have_cur = 0;
        end
      end else if (bus_ads_o && junk) begin
        bus_rdy_i = 1; bus_ken_i = 1; bus_dat_i = 64'hDEAD_BEEF_DEAD_BEEF;
      end
      if (bus_ads_o) pend.push_back('{bus_addr_o, bus_wr_o, bus_cache_o});
    end
  end

  // monitor / scoreboard
  initial begin
    ads_t ea; rd_t er; bit eb;
    forever begin
      @(negedge clk); #2;
      if (!rst_n) continue;
      if (bus_ads_o) begin
        ads_cyc.push_back(cyc);
        if (aq.size() == 0) begin
          checks++; errs++;
          $display("FAIL R2 unexpected strobe actual=1 expected=0");
        end else begin
          ea = aq.pop_front();
          ck("R2", "strobe address", 64'(bus_addr_o), 64'(ea.a));
          ck("R2", "strobe direction", 64'(bus_wr_o), 64'(ea.wr));
          ck("R2", "strobe cache intent", 64'(bus_cache_o), 64'(ea.c));
        end
        if (done_o) begin
          checks++; errs++;
          $display("FAIL R9 strobe with done actual=1 expected=0");
        end
      end
      if (rd_valid_o) begin
        if (rdq.size() == 0) begin
          checks++; errs++;
          $display("FAIL R4 unexpected fill beat actual=%0h expected=none", rd_qw_o);
        end else begin
          er = rdq.pop_front();
          ck("R5", "fill quadword index", 64'(rd_qw_o), 64'(er.qw));
          ck("R4", "fill data", rd_data_o, er.d);
        end
      end
      if (done_o) begin
        done_cyc.push_back(cyc);
        if (dq.size() == 0) begin
          checks++; errs++;
          $display("FAIL R6 unexpected done actual=1 expected=0");
        end else begin
          eb = dq.pop_front();
          ck("R6", "burst flag at done", 64'(done_burst_o), 64'(eb));
        end
      end
    end
  end

  task automatic issue(logic [AW-1:0] a, bit wr, bit c);
    logic [AW-1:0] ab;
    int nb;
    ab = {a[AW-1:3], 3'b000};
    nb = (wr || (c && ken_cfg)) ? NB : 1;
    @(negedge clk); #1;
    req_valid_i = 1; req_op_i = wr ? OP_WB : OP_FILL; req_cache_i = c;
    req_addr_i = a; req_line_i = wr ? wbline(ab) : '0;
    forever begin
      if (req_ready_o) break;
      @(negedge clk); #1;
    end
    aq.push_back('{ab, wr, wr | c});
    if (!wr)
      for (int b = 0; b < nb; b++)
        rdq.push_back('{a[4:3] ^ 2'(b), memq(ab, int'(a[4:3] ^ 2'(b)))});
    dq.push_back(nb > 1);
    @(posedge clk); #1;
    req_valid_i = 0;
  endtask

  task automatic quiet();
    do @(negedge clk);
    while (rdq.size() || dq.size() || aq.size() || have_cur || pend.size());
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_marks();
    ads_cyc.delete(); done_cyc.delete();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    ck("R1", "reset strobe", 64'(bus_ads_o), 0);
    ck("R1", "reset drive enable", 64'(bus_dat_oe_o), 0);
    ck("R1", "reset fill valid", 64'(rd_valid_o), 0);
    ck("R1", "reset done", 64'(done_o), 0);
    ck("R1", "reset ready", 64'(req_ready_o), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4: burst fill from quadword 0, no waits
    clear_marks(); waits = 0; ken_cfg = 1;
    issue(32'h0000_1000, 0, 1); quiet();
    ck("R4", "burst duration", 64'(done_cyc[0] - ads_cyc[0]), 64'((waits+1)*NB + 1));

    // R5 R7: start at quadword 2 with wait states
    clear_marks(); waits = 2;
    issue(32'h0000_2050, 0, 1); quiet();
    ck("R7", "duration with waits", 64'(done_cyc[0] - ads_cyc[0]), 64'((waits+1)*NB + 1));

    // R6: cache-enable low at first ready -> single
    clear_marks(); waits = 0; ken_cfg = 0;
    issue(32'h0000_3078, 0, 1); quiet();
    ck("R6", "single duration", 64'(done_cyc[0] - ads_cyc[0]), 64'd2);

    // R6 R2: no cache intent, cache-enable high -> single
    clear_marks(); ken_cfg = 1;
    issue(32'h0000_4048, 0, 0); quiet();
    ck("R6", "no-intent single duration", 64'(done_cyc[0] - ads_cyc[0]), 64'd2);

    // R8: writeback ignores cache-enable, waits between beats
    clear_marks(); ken_cfg = 0; waits = 1;
    issue(32'h0000_5008, 1, 0); quiet();
    ck("R8", "writeback duration", 64'(done_cyc[0] - ads_cyc[0]), 64'((waits+1)*NB + 1));

    // R3: ready during strobe cycle is not counted
    clear_marks(); ken_cfg = 1; waits = 0; junk = 1;
    issue(32'h0000_6028, 0, 1); quiet();
    junk = 0;
    ck("R3", "burst unaffected by early ready", 64'(done_cyc[0] - ads_cyc[0]), 64'((waits+1)*NB + 1));

    // R10 R11: next-address on first ready, three queued requests
    clear_marks(); waits = 1; na_beat = 0;
    fork
      begin
        issue(32'h0000_7000, 0, 1);
        issue(32'h0000_7118, 0, 1);
        issue(32'h0000_7210, 1, 0);
      end
    join
    quiet();
    ck("R10", "early strobe before first done", 64'(ads_cyc[1] < done_cyc[0]), 64'd1);
    ck("R10", "second data after first done", 64'(done_cyc[1] - done_cyc[0] >= (waits+1)*NB), 64'd1);
    ck("R11", "third strobe waits for first end", 64'(ads_cyc[2] > done_cyc[0]), 64'd1);

    // R11: next-address on second beat ignored
    clear_marks(); na_beat = 1;
    issue(32'h0000_8000, 0, 1);
    issue(32'h0000_8108, 0, 1);
    quiet();
    ck("R11", "late next-address ignored", 64'(ads_cyc[1] > done_cyc[0]), 64'd1);

    // R9: back-to-back without next-address keeps an idle clock
    clear_marks(); na_beat = -1; waits = 0;
    issue(32'h0000_9000, 0, 1);
    issue(32'h0000_9210, 1, 0);
    quiet();
    ck("R9", "idle clock before next strobe", 64'(ads_cyc[1] > done_cyc[0]), 64'd1);

    ck("R4", "leftover fill items", 64'(rdq.size()), 0);
    ck("R2", "leftover strobes", 64'(aq.size()), 0);
    summary();
    $finish;
  end
endmodule